// File: doc/BRIEF.md
# SPD Utility Command Engine

This block sits between the two-wire bus front end and the memory engine of a serial-presence-detect memory. It interprets the utility commands: those whose address byte starts with the utility preamble instead of the memory preamble. It holds four software write-protect flags, one for each quarter of the memory, and the one-bit active bank register. For every byte that belongs to a utility transaction it gives an ACK or NoACK decision. State is reported only through that decision and never through data bytes.

The front end reports a START, a STOP and each received byte as single-cycle events, together with a flag from the pad that detects the high-voltage qualifier on the A0 address pin. A protect change or a bank change is armed during the transaction. It takes effect at the STOP that closes that transaction. A protect change also raises a one-cycle request for a non-volatile write cycle. The memory engine reads the flags and the bank bit. It can also present a byte address and get back whether a write there is locked.

Top module: `spd_util_engine`

## Requirements
- R1: Only the first byte after a START whose upper nibble equals the utility preamble (0110) starts a utility transaction. For every byte of such a transaction, ack_valid_o is high in the cycle after byte_valid_i, with ack_o=1 for ACK and ack_o=0 for NoACK. Any other first byte gives no ack_valid_o for the rest of the transaction.
- R2: In the address byte, bits [3:1] are the select code and bit 0 is R/W. With R/W=0, select 001, 100, 101 and 000 set the protect flag of blocks 0, 1, 2 and 3. If that flag is clear, the address byte, the dummy address byte and the dummy data byte (the latter only with the qualifier high) are ACKed. The flag is then set at STOP and wr_start_o pulses in the cycle after STOP.
- R3: A set-protect aimed at a block that is already protected is NoACKed on all of its bytes. It changes nothing and requests no write cycle.
- R4: If hv_i is low while the third byte of a set-protect or clear-all is received, that byte is NoACKed and the command is not executed.
- R5: Select 011 with R/W=0 clears all four flags at STOP and pulses wr_start_o. All three of its bytes are ACKed when the qualifier is present.
- R6: With R/W=1, select 001, 100, 101 and 000 query the flags of blocks 0 to 3. The address byte is ACKed when the flag is clear and NoACKed when it is set. No state changes.
- R7: Select 110 (bank 0) and 111 (bank 1) with R/W=0 are ACKed on all three bytes whatever hv_i is. They change bank_o at STOP and never pulse wr_start_o.
- R8: Select 110 with R/W=1 is ACKed when bank 0 is active and NoACKed when bank 1 is active.
- R9: The reserved encodings (select 010 with R/W=0; select 010, 011 and 111 with R/W=1) are NoACKed on every byte and change no state.
- R10: Flags and bank change only at a STOP that ends an armed transaction. A repeated START or abort_i before the STOP discards the command.
- R11: mem_lock_o equals the flag of block {bank_o, mem_addr_i[7]}: block 0 is 0x00-0x7F of bank 0, block 1 is 0x80-0xFF of bank 0, block 2 is 0x00-0x7F of bank 1, and block 3 is 0x80-0xFF of bank 1.
- R12: rst_ni returns the bank to 0 and idles the sequencer but keeps the flags. init_ni (delivery state) clears the flags and the bank.
- R13: Bytes after the third byte of a write-type utility command are NoACKed, and they leave the armed command in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low async reset; flags kept |
| init_ni | input | 1 | Active-low async delivery reset; clears flags and bank |
| abort_i | input | 1 | Bus timeout; drops the current transaction |
| start_i | input | 1 | START or repeated START seen |
| stop_i | input | 1 | STOP seen |
| byte_valid_i | input | 1 | A byte from the master is complete |
| byte_i | input | 8 | Received byte |
| hv_i | input | 1 | High-voltage qualifier present on A0 |
| mem_addr_i | input | 8 | Byte address checked for write lock |
| ack_valid_o | output | 1 | An ACK decision is presented |
| ack_o | output | 1 | 1 = ACK, 0 = NoACK |
| wr_start_o | output | 1 | Non-volatile write cycle request pulse |
| prot_o | output | 4 | Protect flags, bit n = block n |
| bank_o | output | 1 | Active bank |
| mem_lock_o | output | 1 | Flag that covers mem_addr_i in the active bank |

## Verification
The assertions assume that the front end never raises byte_valid_i, start_i, stop_i or abort_i in the same cycle, and that it reports a byte only after a START. The bench drives every event as an isolated one-cycle pulse on the falling edge, with idle cycles between them, so this assumption always holds. hv_i is changed only between transactions. That is stricter than the sampling point the design uses, so the qualifier check at the third byte is always well defined.

// File: rtl/spd_util_pkg.sv
package spd_util_pkg;
  typedef enum logic [2:0] {
    K_SETP, K_CLRP, K_SETB0, K_SETB1, K_QRYP, K_QRYB, K_RSVD
  } ucmd_e;

  localparam int unsigned BLK_N  = 4;
  localparam int unsigned BLK_W  = $clog2(BLK_N);
  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/spd_util_decode.sv
module spd_util_decode
  import spd_util_pkg::*;
#(
  parameter logic [3:0] PRE = 4'b0110
) (
  input  logic [BYTE_W-1:0] byte_i,
  input  logic [BLK_N-1:0]  prot_i,
  input  logic              bank_i,
  output logic              is_util_o,
  output ucmd_e             kind_o,
  output logic [BLK_W-1:0]  blk_o,
  output logic              addr_ack_o
);
  logic [2:0] sel;
  logic       rw;
  logic       blk_hit;

  assign sel       = byte_i[3:1];
  assign rw        = byte_i[0];
  assign is_util_o = (byte_i[7:4] == PRE);

  always_comb begin
    blk_hit = 1'b1;
    unique case (sel)
      3'b001:  blk_o = 2'd0;
      3'b100:  blk_o = 2'd1;
      3'b101:  blk_o = 2'd2;
      3'b000:  blk_o = 2'd3;
      default: begin blk_o = 2'd0; blk_hit = 1'b0; end
    endcase
  end

  always_comb begin
    if (blk_hit) kind_o = rw ? K_QRYP : K_SETP;
    else begin
      unique case ({sel, rw})
        4'b0110: kind_o = K_CLRP;
        4'b1100: kind_o = K_SETB0;
        4'b1110: kind_o = K_SETB1;
        4'b1101: kind_o = K_QRYB;
        default: kind_o = K_RSVD;
      endcase
    end
  end

  always_comb begin
    unique case (kind_o)
      K_SETP, K_QRYP:           addr_ack_o = ~prot_i[blk_o];
      K_CLRP, K_SETB0, K_SETB1: addr_ack_o = 1'b1;
      K_QRYB:                   addr_ack_o = ~bank_i;
      default:                  addr_ack_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/spd_util_seq.sv
module spd_util_seq
  import spd_util_pkg::*;
#(
  parameter logic [3:0] PRE = 4'b0110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_ni,
  input  logic              abort_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_valid_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              hv_i,
  input  logic [BLK_N-1:0]  prot_i,
  input  logic              bank_i,
  output logic              ack_valid_o,
  output logic              ack_o,
  output logic              commit_o,
  output ucmd_e             kind_o,
  output logic [BLK_W-1:0]  blk_o
);
  logic             rst_n;
  logic             exp_addr_q;
  logic [1:0]       phase_q;
  logic             alive_q;
  logic             armed_q;
  ucmd_e            kind_q;
  logic [BLK_W-1:0] blk_q;

  logic             d_util, d_ack;
  ucmd_e            d_kind;
  logic [BLK_W-1:0] d_blk;
  logic             bank_cmd;

  assign rst_n = rst_ni & init_ni;

  spd_util_decode #(.PRE(PRE)) u_dec (
    .byte_i    (byte_i),
    .prot_i    (prot_i),
    .bank_i    (bank_i),
    .is_util_o (d_util),
    .kind_o    (d_kind),
    .blk_o     (d_blk),
    .addr_ack_o(d_ack)
  );

  assign bank_cmd = (kind_q == K_SETB0) || (kind_q == K_SETB1);
  assign commit_o = stop_i & armed_q & ~abort_i & ~start_i;
  assign kind_o   = kind_q;
  assign blk_o    = blk_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      exp_addr_q  <= 1'b0;
      phase_q     <= 2'd0;
      alive_q     <= 1'b0;
      armed_q     <= 1'b0;
      kind_q      <= K_RSVD;
      blk_q       <= '0;
      ack_valid_o <= 1'b0;
      ack_o       <= 1'b0;
    end else begin
      ack_valid_o <= 1'b0;
      ack_o       <= 1'b0;
      if (abort_i || start_i || stop_i) begin
        exp_addr_q <= start_i & ~abort_i;
        phase_q    <= 2'd0;
        alive_q    <= 1'b0;
        armed_q    <= 1'b0;
      end else if (byte_valid_i) begin
        if (exp_addr_q) begin
          exp_addr_q <= 1'b0;
          kind_q     <= d_kind;
          blk_q      <= d_blk;
          if (d_util) begin
            phase_q     <= 2'd1;
            ack_valid_o <= 1'b1;
            ack_o       <= d_ack;
            alive_q     <= d_ack & ~byte_i[0];
          end else begin
            phase_q <= 2'd0;
            alive_q <= 1'b0;
          end
        end else if (phase_q != 2'd0) begin
          ack_valid_o <= 1'b1;
          unique case (phase_q)
            2'd1: begin
              ack_o   <= alive_q;
              phase_q <= 2'd2;
            end
            2'd2: begin
              ack_o   <= alive_q & (bank_cmd | hv_i);
              armed_q <= alive_q & (bank_cmd | hv_i);
              phase_q <= 2'd3;
            end
            default: ack_o <= 1'b0;  // extra bytes: NoACK, command kept
          endcase
        end
      end
    end
  end

  p_ack_after_byte_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    ack_valid_o |-> $past(byte_valid_i));

  p_hv_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($rose(armed_q) && (kind_q == K_SETP || kind_q == K_CLRP)) |-> $past(hv_i));

  p_rsvd_noack_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ack_valid_o && kind_q == K_RSVD) |-> !ack_o);

  p_extra_noack_r13: assert property (@(posedge clk_i) disable iff (!rst_n)
    (ack_valid_o && $past(phase_q) == 2'd3) |-> !ack_o);
endmodule

// File: rtl/spd_util_state.sv
module spd_util_state
  import spd_util_pkg::*;
#(
  parameter int unsigned MEM_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_ni,
  input  logic              commit_i,
  input  ucmd_e             kind_i,
  input  logic [BLK_W-1:0]  blk_i,
  input  logic [MEM_AW-1:0] mem_addr_i,
  output logic [BLK_N-1:0]  prot_o,
  output logic              bank_o,
  output logic              wr_start_o,
  output logic              mem_lock_o
);
  logic             bank_rst_n;
  logic [BLK_W-1:0] lock_idx;

  assign bank_rst_n = rst_ni & init_ni;

  for (genvar g = 0; g < BLK_N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge init_ni) begin
      if (!init_ni) prot_o[g] <= 1'b0;
      else if (commit_i) begin
        if (kind_i == K_CLRP)                          prot_o[g] <= 1'b0;
        else if (kind_i == K_SETP && blk_i == BLK_W'(g)) prot_o[g] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge bank_rst_n) begin
    if (!bank_rst_n) begin
      bank_o     <= 1'b0;
      wr_start_o <= 1'b0;
    end else begin
      wr_start_o <= commit_i & (kind_i == K_SETP || kind_i == K_CLRP);
      if (commit_i && kind_i == K_SETB0) bank_o <= 1'b0;
      if (commit_i && kind_i == K_SETB1) bank_o <= 1'b1;
    end
  end

  assign lock_idx   = {bank_o, mem_addr_i[MEM_AW-1]};
  assign mem_lock_o = prot_o[lock_idx];

  p_flags_on_commit_r10: assert property (@(posedge clk_i) disable iff (!bank_rst_n)
    (prot_o != $past(prot_o)) |-> $past(commit_i));

  p_bank_no_wr_r7: assert property (@(posedge clk_i) disable iff (!bank_rst_n)
    (bank_o != $past(bank_o)) |-> !wr_start_o);
endmodule

// File: rtl/spd_util_engine.sv
module spd_util_engine
  import spd_util_pkg::*;
#(
  parameter logic [3:0]  PRE    = 4'b0110,
  parameter int unsigned MEM_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_ni,
  input  logic              abort_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              hv_i,
  input  logic [MEM_AW-1:0] mem_addr_i,
  output logic              ack_valid_o,
  output logic              ack_o,
  output logic              wr_start_o,
  output logic [3:0]        prot_o,
  output logic              bank_o,
  output logic              mem_lock_o
);
  logic             commit;
  ucmd_e            kind;
  logic [BLK_W-1:0] blk;

  spd_util_seq #(.PRE(PRE)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .init_ni      (init_ni),
    .abort_i      (abort_i),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .byte_valid_i (byte_valid_i),
    .byte_i       (byte_i),
    .hv_i         (hv_i),
    .prot_i       (prot_o),
    .bank_i       (bank_o),
    .ack_valid_o  (ack_valid_o),
    .ack_o        (ack_o),
    .commit_o     (commit),
    .kind_o       (kind),
    .blk_o        (blk)
  );

  spd_util_state #(.MEM_AW(MEM_AW)) u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_ni    (init_ni),
    .commit_i   (commit),
    .kind_i     (kind),
    .blk_i      (blk),
    .mem_addr_i (mem_addr_i),
    .prot_o     (prot_o),
    .bank_o     (bank_o),
    .wr_start_o (wr_start_o),
    .mem_lock_o (mem_lock_o)
  );

  p_wr_after_stop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !init_ni)
    wr_start_o |-> $past(stop_i));
endmodule

// File: tb/sim_spd_util_engine.sv
module sim_spd_util_engine;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, init_n = 1'b0, abort = 1'b0, start = 1'b0, stop = 1'b0;
  logic bv = 1'b0, hv = 1'b0;
  logic [7:0] byt = '0, maddr = '0;
  logic ack_v, ack, wr, bank, lock;
  logic [3:0] prot;

  int errs = 0, chks = 0;
  logic [3:0] m_prot = '0;
  logic       m_bank = 1'b0;

  spd_util_engine u0 (
    .clk_i(clk), .rst_ni(rst_n), .init_ni(init_n), .abort_i(abort),
    .start_i(start), .stop_i(stop), .byte_valid_i(bv), .byte_i(byt),
    .hv_i(hv), .mem_addr_i(maddr), .ack_valid_o(ack_v), .ack_o(ack),
    .wr_start_o(wr), .prot_o(prot), .bank_o(bank), .mem_lock_o(lock)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
  endtask
  task automatic pulse_stop(output logic w);
    @(negedge clk); stop = 1'b1; @(negedge clk); stop = 1'b0; w = wr;
  endtask
  task automatic pulse_abort();
    @(negedge clk); abort = 1'b1; @(negedge clk); abort = 1'b0;
  endtask
  task automatic send(input logic [7:0] b, output logic av, output logic ak);
    @(negedge clk); bv = 1'b1; byt = b; @(negedge clk); bv = 1'b0; av = ack_v; ak = ack;
  endtask

  // block index for a select code, -1 if none (R2/R6 encoding)
  function automatic int blk_of(input logic [2:0] s);
    case (s)
      3'b001: return 0;
      3'b100: return 1;
      3'b101: return 2;
      3'b000: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] s, input logic rw, input logic [3:0] p);
    int b = blk_of(s);
    if (b >= 0) return rw ? "R6" : (p[b] ? "R3" : "R2");
    if (!rw && s == 3'b011) return "R5";
    if (!rw && s[2:1] == 2'b11) return "R7";
    if (rw && s == 3'b110) return "R8";
    return "R9";
  endfunction

  // endm: 0 stop, 1 repeated start then stop, 2 abort
  task automatic run_cmd(input logic [2:0] s, input logic rw, input logic h,
                         input int n, input int endm);
    int b = blk_of(s);
    string t = tag_of(s, rw, m_prot);
    logic av, ak, w, e_addr, alive, bcmd, e_commit;
    bcmd = !rw && s[2:1] == 2'b11;
    if (b >= 0)                  e_addr = !m_prot[b];
    else if (!rw && s == 3'b011) e_addr = 1'b1;
    else if (bcmd)               e_addr = 1'b1;
    else if (rw && s == 3'b110)  e_addr = !m_bank;
    else                         e_addr = 1'b0;
    alive = !rw && e_addr;
    hv = h;
    pulse_start();
    send({4'b0110, s, rw}, av, ak);
    chk(av === 1'b1, "R1", int'(av), 1);
    chk(ak === e_addr, t, int'(ak), int'(e_addr));
    if (!rw) begin
      for (int i = 2; i <= n; i++) begin
        logic ea;
        string tt;
        ea = (i == 2) ? alive : (i == 3) ? (alive && (bcmd || h)) : 1'b0;
        tt = (i > 3) ? "R13" : (i == 3 && alive && !bcmd && !h) ? "R4" : t;
        send(8'h5A + 8'(i), av, ak);
        chk(av === 1'b1 && ak === ea, tt, int'(ak), int'(ea));
      end
    end
    e_commit = alive && n >= 3 && (bcmd || h) && endm == 0;
    if (endm == 1) pulse_start();
    if (endm == 2) pulse_abort();
    pulse_stop(w);
    chk(w === (e_commit && !bcmd), (endm != 0) ? "R10" : (bcmd ? "R7" : t),
        int'(w), int'(e_commit && !bcmd));
    if (e_commit) begin
      if (b >= 0) m_prot[b] = 1'b1;
      else if (s == 3'b011) m_prot = '0;
      else m_bank = s[0];
    end
    chk(prot === m_prot, (endm != 0) ? "R10" : t, int'(prot), int'(m_prot));
    chk(bank === m_bank, (endm != 0) ? "R10" : t, int'(bank), int'(m_bank));
  endtask

  task automatic lock_sweep();
    for (int a = 0; a < 256; a++) begin
      logic e;
      @(negedge clk); maddr = 8'(a);
      #1;
      e = m_prot[{m_bank, maddr[7]}];
      chk(lock === e, "R11", int'(lock), int'(e));
    end
  endtask

  initial begin
    #(4 * 150000);
    errs++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  initial begin
    logic av, ak, w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; init_n = 1'b1;
    @(negedge clk);
    chk(prot === 4'h0 && bank === 1'b0 && ack_v === 1'b0 && wr === 1'b0, "R12",
        int'({prot, bank}), 0);

    // R1: memory preamble is not ours
    pulse_start();
    send(8'hA0, av, ak);
    chk(av === 1'b0, "R1", int'(av), 0);
    send(8'h00, av, ak);
    chk(av === 1'b0, "R1", int'(av), 0);
    pulse_stop(w);

    // sweeps over every select/R/W code, both qualifier levels, three endings
    for (int rnd = 0; rnd < 4; rnd++)
      for (int h = 0; h < 2; h++)
        for (int c = 0; c < 16; c++)
          run_cmd(3'(c >> 1), c[0], h[0], (rnd == 1) ? 4 : 3,
                  (rnd == 2) ? (c % 3) : 0);

    // explicit states for lock map: each block alone in each bank
    for (int bk = 0; bk < 2; bk++) begin
      run_cmd(3'b110 | 3'(bk), 1'b0, 1'b0, 3, 0);
      for (int b = 0; b < 4; b++) begin
        run_cmd(3'b011, 1'b0, 1'b1, 3, 0);
        run_cmd((b == 0) ? 3'b001 : (b == 1) ? 3'b100 : (b == 2) ? 3'b101 : 3'b000,
                1'b0, 1'b1, 3, 0);
        lock_sweep();
      end
    end

    // R12: rst_ni keeps flags, clears bank; init_ni clears both
    run_cmd(3'b111, 1'b0, 1'b0, 3, 0);
    run_cmd(3'b001, 1'b0, 1'b1, 3, 0);
    @(negedge clk); rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
    m_bank = 1'b0;
    @(negedge clk);
    chk(prot === m_prot, "R12", int'(prot), int'(m_prot));
    chk(bank === 1'b0, "R12", int'(bank), 0);
    @(negedge clk); init_n = 1'b0; @(negedge clk); init_n = 1'b1;
    m_prot = '0;
    @(negedge clk);
    chk(prot === 4'h0 && bank === 1'b0, "R12", int'({prot, bank}), 0);

    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule